// File: doc/BRIEF.md
# Packed 10-bit YUV 4:2:2 Unpacker

This block accepts a stream of 32-bit words. Each word carries three 10-bit video samples, and the block turns them into one pixel per output handshake. Each pixel is a 10-bit luma value paired with the 10-bit chroma sample that belongs to it. The samples run in a fixed pattern that repeats every four words (twelve samples, six pixels). Inside that pattern, chroma and luma alternate, so every luma sample is preceded by the chroma sample it is paired with.

A programmed line width, given in pixels, marks where each line ends. A line always occupies a whole number of words. When the width is not a multiple of six, the samples left over in the final word of a line are thrown away, and the next line starts again at the head of the pattern. Both edges of the block use a valid/ready handshake. The pixel side also flags the first and the last pixel of each line. The line width must be at least 1 and must only be changed while the block is idle.

Top module: `yuv10_unpack`

## Requirements
- R1: A word's samples lie in bits 9:0 (taken first), 19:10 (second) and 29:20 (third). Bits 31:30 have no effect on any output.
- R2: Within a four-word group, the samples in order are U1 Y1 V1 Y2 U2 Y3 V2 Y4 U3 Y5 V3 Y6. Pixels leave in the order Y1..Y6, paired with chroma U1, V1, U2, V2, U3, V3 in that order.
- R3: out_sol is high with the first pixel of every line, and out_eol is high with pixel number line_width. After an end-of-line pixel is taken, the next pixel carries out_sol. Both are high together only when line_width is 1.
- R4: After pixel line_width, the rest of the current word is dropped, and the next word starts a new group at sample U1. A line of W pixels therefore consumes ceil(2W/3) words.
- R5: While out_valid is high and out_ready is low, the pixel is held: out_valid, out_luma, out_chroma, out_sol and out_eol do not change.
- R6: A word is accepted only when the internal holding slot is empty or is being emptied in the same cycle. No accepted word is lost or used twice.
- R7: While rst_n is low, and right after it, out_valid is low and in_ready is high. The next word accepted begins a new line and a new group.
- R8: A pixel is offered two cycles after the word holding its chroma sample is accepted into an empty block. When words are always available and out_ready stays high, pixels follow one another exactly every two cycles, and there are never two pixels in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| line_width | input | LINE_BITS | Pixels per line, at least 1, changed only while idle |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | WORD_W | Packed word of three samples |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel this cycle |
| out_luma | output | SAMP_W | Luma sample of the pixel |
| out_chroma | output | SAMP_W | Chroma sample paired with the pixel |
| out_sol | output | 1 | First pixel of a line |
| out_eol | output | 1 | Last pixel of a line |

## Verification
Results are tied to handshakes, not to a fixed cycle number. The bench drives inputs on the falling edge and waits one time step. It then records every handshake that the next rising edge will complete, so each pixel is compared in the very cycle it is offered. The cycle-exact results are the first pixel, which appears two cycles after its word is accepted into an empty block, and the spacing of exactly two cycles between pixels when nothing stalls. The bench measures both with a cycle counter. The word count for each line (R4) and the absence of stray pixels are checked a few cycles after each line's expected pixels have all been seen.

// File: rtl/yuv10_pkg.sv
// Package: constants of the packed three-samples-per-word layout, and the
// shared types used by the unpacker modules.
// Assumes: the layout is fixed at three samples per word and four words per
// group, so these are package constants rather than module parameters.
package yuv10_pkg;
    localparam int SAMPLES_PER_WORD  = 3;
    localparam int WORDS_PER_GROUP   = 4;
    localparam int SAMPLES_PER_GROUP = SAMPLES_PER_WORD * WORDS_PER_GROUP;
    localparam int PHASE_W           = $clog2(SAMPLES_PER_GROUP);
    localparam int FIELD_W           = $clog2(SAMPLES_PER_WORD);

    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/yuv10_word_slot.sv
// Word slot: holds one accepted input word and presents the field that the
// sequencer selects. Only the sample bits are stored; the top bits are dropped.
// Assumes: load takes priority over release in the same cycle, so a word can be
// refilled while the last useful field of the previous word is being consumed.
module yuv10_word_slot
    import yuv10_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              release_slot,
    input  logic [WORD_W-1:0] in_word,
    input  field_t            field,
    output logic              full,
    output logic [SAMP_W-1:0] sample
);
    localparam int USED_W = SAMPLES_PER_WORD * SAMP_W;

    logic [USED_W-1:0] word_q;
    logic [SAMP_W-1:0] lanes [SAMPLES_PER_WORD];
    logic              unused_top;

    // Fold the non-sample top bits into a deliberately unused net.
    assign unused_top = ^in_word[WORD_W-1:USED_W];

    // Track whether the slot holds a word.
    always_ff @(posedge clk) begin
        if (!rst_n)            full <= 1'b0;
        else if (load)         full <= 1'b1;
        else if (release_slot) full <= 1'b0;
    end

    // Capture the sample bits of a newly accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '0;
        else if (load) word_q <= in_word[USED_W-1:0];
    end

    // Split the stored word into its sample lanes, lowest bits first.
    for (genvar g = 0; g < SAMPLES_PER_WORD; g++) begin : g_lane
        assign lanes[g] = word_q[g*SAMP_W +: SAMP_W];
    end

    // Present the lane chosen by the sequencer.
    always_comb begin
        sample = lanes[0];
        for (int i = 1; i < SAMPLES_PER_WORD; i++)
            if (field == field_t'(i)) sample = lanes[i];
    end
endmodule

// File: rtl/yuv10_phase_seq.sv
// Sample sequencer: counts the position within the twelve-sample group and
// the field within the current word. Even positions are chroma, odd are luma.
// Assumes: step is asserted only when a sample is really consumed, and
// restart (end of line) returns both counters to the head of a group.
module yuv10_phase_seq
    import yuv10_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    input  logic   restart,
    output phase_t phase,
    output field_t field,
    output logic   is_luma,
    output logic   field_last
);
    localparam phase_t PH_LAST  = phase_t'(SAMPLES_PER_GROUP - 1);
    localparam field_t FLD_LAST = field_t'(SAMPLES_PER_WORD - 1);

    // Advance the group position, wrapping after the last sample or at line end.
    always_ff @(posedge clk) begin
        if (!rst_n)                        phase <= '0;
        else if (step && restart)          phase <= '0;
        else if (step && phase == PH_LAST) phase <= '0;
        else if (step)                     phase <= phase + phase_t'(1);
    end

    // Advance the field within the word, wrapping at the third lane or line end.
    always_ff @(posedge clk) begin
        if (!rst_n)                         field <= '0;
        else if (step && restart)           field <= '0;
        else if (step && field == FLD_LAST) field <= '0;
        else if (step)                      field <= field + field_t'(1);
    end

    assign is_luma    = phase[0];
    assign field_last = (field == FLD_LAST);
endmodule

// File: rtl/yuv10_line_ctr.sv
// Line counter: counts pixels handed out in the current line and flags the
// first and last pixel positions.
// Assumes: line_width is at least 1 and stays constant while a line is in
// flight.
module yuv10_line_ctr #(
    parameter int LINE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_step,
    input  logic [LINE_BITS-1:0] line_width,
    output logic                 first,
    output logic                 last
);
    logic [LINE_BITS-1:0] px_q;

    // Count pixels in the line, clearing after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)                px_q <= '0;
        else if (pix_step && last) px_q <= '0;
        else if (pix_step)         px_q <= px_q + LINE_BITS'(1);
    end

    assign first = (px_q == '0);
    assign last  = (px_q == line_width - LINE_BITS'(1));
endmodule

// File: rtl/yuv10_unpack.sv
// Top: unpacks 10-bit 4:2:2 samples from packed words into luma/chroma pixels.
// It consumes one sample per cycle. A chroma sample is latched internally;
// the luma sample that follows is offered together with it as one pixel.
// Assumes: line_width >= 1, changed only while idle; in_ready depends
// combinationally on out_ready.
module yuv10_unpack
    import yuv10_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int SAMP_W    = 10,
    parameter int LINE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINE_BITS-1:0] line_width,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_word,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [SAMP_W-1:0]    out_luma,
    output logic [SAMP_W-1:0]    out_chroma,
    output logic                 out_sol,
    output logic                 out_eol
);
    logic              full;
    logic [SAMP_W-1:0] sample;
    phase_t            phase;
    field_t            field;
    logic              is_luma;
    logic              field_last;
    logic              line_first;
    logic              line_last;
    logic              advance;
    logic              pix_step;
    logic              line_done;
    logic              release_slot;
    logic              load;
    logic [SAMP_W-1:0] chroma_q;
    logic              unused_phase;

    // The full group position is only needed for its luma/chroma bit here.
    assign unused_phase = ^phase;

    // Consume a sample: chroma goes freely, luma waits for the consumer.
    assign advance      = full && (!is_luma || out_ready);
    assign pix_step     = advance && is_luma;
    assign line_done    = pix_step && line_last;
    assign release_slot = advance && (field_last || line_done);
    assign load         = in_valid && in_ready;
    assign in_ready     = !full || release_slot;

    yuv10_word_slot #(
        .WORD_W (WORD_W),
        .SAMP_W (SAMP_W)
    ) i_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .release_slot (release_slot),
        .in_word      (in_word),
        .field        (field),
        .full         (full),
        .sample       (sample)
    );

    yuv10_phase_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (advance),
        .restart    (line_done),
        .phase      (phase),
        .field      (field),
        .is_luma    (is_luma),
        .field_last (field_last)
    );

    yuv10_line_ctr #(
        .LINE_BITS (LINE_BITS)
    ) i_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_step   (pix_step),
        .line_width (line_width),
        .first      (line_first),
        .last       (line_last)
    );

    // Hold the chroma sample that precedes the next luma sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                  chroma_q <= '0;
        else if (advance && !is_luma) chroma_q <= sample;
    end

    assign out_valid  = full && is_luma;
    assign out_luma   = sample;
    assign out_chroma = chroma_q;
    assign out_sol    = line_first;
    assign out_eol    = line_last;
endmodule

// File: rtl/yuv10_unpack_chk.sv
// Checker: protocol and line-marker properties of the unpacker's pixel side.
// Assumes: bound into every instance of yuv10_unpack; observes ports only.
module yuv10_unpack_chk #(
    parameter int SAMP_W    = 10,
    parameter int LINE_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LINE_BITS-1:0] line_width,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [SAMP_W-1:0]    out_luma,
    input logic [SAMP_W-1:0]    out_chroma,
    input logic                 out_sol,
    input logic                 out_eol
);
    // R5
    pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_luma) &&
        $stable(out_chroma) && $stable(out_sol) && $stable(out_eol));

    // R3
    eol_then_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eol |=> out_sol);

    // R3
    sol_eol_width_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sol && out_eol |-> line_width == LINE_BITS'(1));

    // R8
    pixel_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid);
endmodule

bind yuv10_unpack yuv10_unpack_chk #(
    .SAMP_W    (SAMP_W),
    .LINE_BITS (LINE_BITS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_width (line_width),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_luma   (out_luma),
    .out_chroma (out_chroma),
    .out_sol    (out_sol),
    .out_eol    (out_eol)
);

// File: tb/test_yuv10_unpack.sv
// Bench: table of line widths, seeds and stall modes walked by one loop,
// then directed tests for reset, first-pixel latency and mid-line reset.
module test_yuv10_unpack;
    localparam int LB   = 12;
    localparam int ROWS = 9;
    // row: width, seed, stall mode (0 free, 1 slow consumer, 2 gappy source), words per line
    localparam int VEC [ROWS][4] = '{
        '{6, 1, 0, 4}, '{12, 2, 1, 8}, '{4, 3, 0, 3}, '{1, 4, 0, 1}, '{5, 5, 1, 4},
        '{2, 6, 2, 2}, '{7, 7, 0, 5}, '{3, 8, 1, 2}, '{9, 9, 2, 6}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [LB-1:0] line_width = LB'(6);
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_word = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [9:0]    out_luma;
    logic [9:0]    out_chroma;
    logic          out_sol;
    logic          out_eol;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          stall_mode = 0;
    int          acc_words = 0;
    int          last_pix_cyc = -1;
    int          first_acc_cyc = -1;
    int          first_pix_cyc = -1;
    bit          spacing_on = 1'b0;
    bit          done = 1'b0;
    logic [31:0] wq [$];
    logic [21:0] eq [$];

    always #10 clk = ~clk;

    yuv10_unpack #(.WORD_W(32), .SAMP_W(10), .LINE_BITS(LB)) i_yuv10_unpack (
        .clk(clk), .rst_n(rst_n), .line_width(line_width),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_luma(out_luma), .out_chroma(out_chroma),
        .out_sol(out_sol), .out_eol(out_eol)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] smp(input int seed, input int line, input int idx);
        return 10'((seed * 97 + line * 211 + idx * 389 + idx * idx * 13) ^ (seed << 5));
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", "run length", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Drive both handshakes at the falling edge and record what the next rising edge completes.
    always @(negedge clk) begin
        if (!rst_n) begin
            in_valid  = 1'b0;
            out_ready = 1'b0;
        end else begin
            out_ready = (stall_mode != 1) || (cyc % 3 == 0);
            in_valid  = (wq.size() > 0) && ((stall_mode != 2) || cyc[0]);
            in_word   = (wq.size() > 0) ? wq[0] : 32'h0;
            #1;
            if (in_valid && in_ready) begin
                void'(wq.pop_front());
                acc_words++;
                if (first_acc_cyc < 0) first_acc_cyc = cyc;
            end
            if (out_valid && out_ready) begin
                if (eq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected pixel", {out_luma, out_chroma}, 0);
                end else begin
                    logic [21:0] exp_px;
                    exp_px = eq.pop_front();
                    // R1 R2 R3: luma, paired chroma, line markers
                    chk({out_sol, out_eol, out_luma, out_chroma} == exp_px, "R1 R2 R3",
                        "pixel {sol,eol,luma,chroma}",
                        {out_sol, out_eol, out_luma, out_chroma}, exp_px);
                end
                if (spacing_on && last_pix_cyc >= 0)
                    chk(cyc - last_pix_cyc == 2, "R8", "pixel spacing", cyc - last_pix_cyc, 2);
                last_pix_cyc = cyc;
                if (first_pix_cyc < 0) first_pix_cyc = cyc;
            end
        end
    end

    // Build one line: chroma then luma per pixel, three samples per word, junk in the tail.
    task automatic build_line(input int w, input int seed, input int line);
        logic [9:0] s [$];
        for (int i = 0; i < w; i++) begin
            logic [9:0] c;
            logic [9:0] y;
            c = smp(seed, line, 2 * i);
            y = smp(seed, line, 2 * i + 1);
            s.push_back(c);
            s.push_back(y);
            eq.push_back({i == 0, i == w - 1, y, c});
        end
        for (int b = 0; b < s.size(); b += 3) begin
            logic [9:0] f1;
            logic [9:0] f2;
            f1 = (b + 1 < s.size()) ? s[b + 1] : smp(seed, line, 1000 + b);
            f2 = (b + 2 < s.size()) ? s[b + 2] : smp(seed, line, 2000 + b);
            wq.push_back({2'(b + 1) | 2'b01, f2, f1, s[b]});
        end
    endtask

    task automatic run_row(input int w, input int seed, input int mode, input int expw);
        int t;
        @(negedge clk);
        #2;
        stall_mode   = mode;
        line_width   = LB'(w);
        acc_words    = 0;
        last_pix_cyc = -1;
        spacing_on   = (mode == 0);
        build_line(w, seed, 0);
        build_line(w, seed, 1);
        t = 0;
        while ((eq.size() > 0 || wq.size() > 0) && t < 4000) begin
            @(posedge clk);
            t++;
        end
        chk(t < 4000, "R6", "line completes", t, 0);
        repeat (4) @(negedge clk);
        #2;
        // R4: whole words per line, leftovers dropped
        chk(acc_words == 2 * expw, "R4", "words consumed", acc_words, 2 * expw);
        chk(out_valid == 1'b0, "R4", "no stray pixel", out_valid, 0);
    endtask

    task automatic apply_reset();
        @(posedge clk);
        #2;
        rst_n = 1'b0;
        wq.delete();
        eq.delete();
        repeat (2) @(posedge clk);
        #2;
        // R7: reset state
        chk(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R7", "in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);
    endtask

    initial begin
        apply_reset();

        // R8: first-pixel latency from an empty block
        first_acc_cyc = -1;
        first_pix_cyc = -1;
        run_row(6, 11, 0, 4);
        chk(first_pix_cyc - first_acc_cyc == 2, "R8", "first pixel latency",
            first_pix_cyc - first_acc_cyc, 2);

        for (int r = 0; r < ROWS; r++)
            run_row(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3]);

        // R7: reset in the middle of a line, then a fresh line starts cleanly
        stall_mode = 1;
        line_width = LB'(6);
        build_line(6, 21, 0);
        repeat (12) @(posedge clk);
        apply_reset();
        run_row(3, 22, 0, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule